// File: doc/BRIEF.md
# Raster Video Timing Generator

This block produces the horizontal and vertical timing of a raster video signal from a small set of programmable registers. Software writes the line period, the field length, the sync and colour-burst widths, and the active-picture and burst windows through a word-wide register bus. From these the block runs a quarter-pixel horizontal counter and a half-line vertical counter, and drives horizontal sync, vertical sync, colour-burst enable, active video, a field indicator and a line interrupt.

The vertical position is counted in half-lines, so an odd field length alternates the line parity from one field to the next, as interlaced output needs. An interrupt is raised when the half-line counter reaches a programmed value and stays raised until software writes the current-line register. The control register is stored in full, but only its two-bit pixel-size field affects the outputs: the blank setting suppresses every timing output while the counters keep running. The line-width and leap registers are stored and read back only.

Top module: `raster_timing_gen`

## Requirements
- R1: Each register keeps the written bits under its mask and reads them back: 0 control 0x0001FFFF, 1 line width 0x00000FFF, 2 interrupt line 0x000003FF, 4 timing 0x3FFFFFFF, 5 field length 0x000003FF, 6 line period 0x001F0FFF, 7 leap 0x0FFF0FFF, 8/9/10 windows 0x03FF03FF. Addresses 11 to 15 read 0.
- R2: While reset is high every register reads 0 except the interrupt line, which reads 0x3FF, and every timing output is low.
- R3: The horizontal counter advances once per clock and returns to 0 on the clock after it reaches line period (address 6 bits [11:0]) minus 1; hsync is high while the counter is below four times the hsync width (address 4 bits [7:0]).
- R4: The half-line counter advances on the clock where the horizontal counter wraps and on the clock where it becomes half the line period (rounded down), once if both coincide; it returns to 0 after reaching field length (address 5 bits [9:0]) minus 1.
- R5: vsync is high while the half-line counter is below the vsync width (address 4 bits [19:16]).
- R6: Active video is high while the pixel index (horizontal counter divided by 4) lies in [start, end) of address 8 (start bits [25:16], end bits [9:0]) and the half-line counter lies in [start, end) of address 9, same layout.
- R7: Burst enable is high while the pixel index lies in [burst start, burst start + burst width) (address 4 bits [29:20] and [15:8]) and the half-line counter lies in [start, end) of address 10.
- R8: Reading address 3 returns the half-line value taken on each horizontal wrap; the field output toggles each time the half-line counter wraps to 0.
- R9: The interrupt output rises on the clock where the half-line counter takes the value in address 2 bits [9:0]; any write to address 3 clears it, a coincident new match taking precedence.
- R10: With pixel size (address 0 bits [1:0]) equal to 0, hsync, vsync, burst enable and active video stay low while both counters keep running; sizes 1 to 3 enable them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one quarter-pixel per cycle |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 4 | Register word address |
| busWrite | input | 1 | Write strobe for busWdata at busAddr |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |
| burstEn | output | 1 | Colour-burst enable |
| videoActive | output | 1 | Active picture window |
| fieldId | output | 1 | Field indicator |
| lineIrq | output | 1 | Line interrupt, sticky |

## Verification
The bench builds the block with its default 32-bit data and 4-bit address parameters and programs very short timings: a 40 and a 33 quarter-pixel line with 7 and 8 half-line fields. These bring field toggling, odd-length lines with unequal half-lines, interrupt set and clear, and reprogramming while the counters run within a few hundred cycles each. A cycle-level model built from the requirements is compared against every output on every cycle.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  localparam int H_W      = 12;
  localparam int V_W      = 10;
  localparam int PX_W     = H_W - 2;
  localparam int NUM_REGS = 11;

  localparam int REG_CTRL    = 0;
  localparam int REG_WIDTH   = 1;
  localparam int REG_IRQLINE = 2;
  localparam int REG_CURLINE = 3;
  localparam int REG_TIMING  = 4;
  localparam int REG_VTOTAL  = 5;
  localparam int REG_HTOTAL  = 6;
  localparam int REG_LEAP    = 7;
  localparam int REG_HWIN    = 8;
  localparam int REG_VWIN    = 9;
  localparam int REG_VBURST  = 10;

  typedef struct packed {
    logic [1:0]      pixSize;
    logic [H_W-1:0]  hPeriod;
    logic [V_W-1:0]  vTotal;
    logic [7:0]      hsyncW;
    logic [7:0]      burstW;
    logic [3:0]      vsyncW;
    logic [PX_W-1:0] burstStart;
    logic [PX_W-1:0] hStart;
    logic [PX_W-1:0] hEnd;
    logic [V_W-1:0]  vStart;
    logic [V_W-1:0]  vEnd;
    logic [V_W-1:0]  vbStart;
    logic [V_W-1:0]  vbEnd;
    logic [V_W-1:0]  intrLine;
  } vtgCfg_t;

  typedef struct packed {
    logic clrIrq;
  } vtgStrobe_t;

  function automatic logic [31:0] regMask(input int idx);
    case (idx)
      REG_CTRL:    return 32'h0001_FFFF;
      REG_WIDTH:   return 32'h0000_0FFF;
      REG_IRQLINE: return 32'h0000_03FF;
      REG_TIMING:  return 32'h3FFF_FFFF;
      REG_VTOTAL:  return 32'h0000_03FF;
      REG_HTOTAL:  return 32'h001F_0FFF;
      REG_LEAP:    return 32'h0FFF_0FFF;
      REG_HWIN, REG_VWIN, REG_VBURST: return 32'h03FF_03FF;
      default:     return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] regReset(input int idx);
    return (idx == REG_IRQLINE) ? 32'h0000_03FF : 32'h0;
  endfunction

endpackage

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [V_W-1:0]    curLine,
  output vtgCfg_t           cfg,
  output vtgStrobe_t        strb
);

  logic [DATA_W-1:0] regFile [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regFile[g] <= regReset(g);
      else if (busWrite && busAddr == ADDR_W'(g))
        regFile[g] <= busWdata & regMask(g);
    end
  end

  always_comb begin
    busRdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (busAddr == ADDR_W'(i)) busRdata = regFile[i];
    if (busAddr == ADDR_W'(REG_CURLINE))
      busRdata = DATA_W'(curLine);
  end

  always_comb begin
    cfg.pixSize    = regFile[REG_CTRL][1:0];
    cfg.hPeriod    = regFile[REG_HTOTAL][H_W-1:0];
    cfg.vTotal     = regFile[REG_VTOTAL][V_W-1:0];
    cfg.hsyncW     = regFile[REG_TIMING][7:0];
    cfg.burstW     = regFile[REG_TIMING][15:8];
    cfg.vsyncW     = regFile[REG_TIMING][19:16];
    cfg.burstStart = regFile[REG_TIMING][29:20];
    cfg.hStart     = regFile[REG_HWIN][25:16];
    cfg.hEnd       = regFile[REG_HWIN][9:0];
    cfg.vStart     = regFile[REG_VWIN][25:16];
    cfg.vEnd       = regFile[REG_VWIN][9:0];
    cfg.vbStart    = regFile[REG_VBURST][25:16];
    cfg.vbEnd      = regFile[REG_VBURST][9:0];
    cfg.intrLine   = regFile[REG_IRQLINE][V_W-1:0];
  end

  assign strb.clrIrq = busWrite && (busAddr == ADDR_W'(REG_CURLINE));

endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  vtgCfg_t        cfg,
  input  vtgStrobe_t     strb,
  output logic [V_W-1:0] curLine,
  output logic           hSync,
  output logic           vSync,
  output logic           burstEn,
  output logic           videoActive,
  output logic           fieldId,
  output logic           lineIrq
);

  logic [H_W-1:0]  hCount, hNext, halfMark, hsEnd;
  logic [H_W:0]    hPlus;
  logic [V_W-1:0]  halfLine, halfNext, curLatch;
  logic [V_W:0]    vPlus;
  logic [PX_W-1:0] pixel;
  logic [PX_W:0]   burstStop;
  logic            lineWrap, advance, vWrap, irqSet, irqFlag, pixOn;
  logic            inHWin, inVWin, inHBurst, inVBurst;

  // horizontal and half-line stepping
  assign hPlus    = {1'b0, hCount} + 1'b1;
  assign lineWrap = hPlus >= {1'b0, cfg.hPeriod};
  assign hNext    = lineWrap ? '0 : hPlus[H_W-1:0];
  assign halfMark = cfg.hPeriod >> 1;
  assign advance  = lineWrap || (hNext == halfMark);
  assign vPlus    = {1'b0, halfLine} + 1'b1;
  assign vWrap    = vPlus >= {1'b0, cfg.vTotal};
  assign halfNext = advance ? (vWrap ? '0 : vPlus[V_W-1:0]) : halfLine;
  assign irqSet   = advance && (halfNext == cfg.intrLine);

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount   <= '0;
      halfLine <= '0;
      curLatch <= '0;
      fieldId  <= 1'b0;
      irqFlag  <= 1'b0;
    end else begin
      hCount   <= hNext;
      halfLine <= halfNext;
      if (lineWrap) curLatch <= halfNext;
      if (advance && vWrap) fieldId <= ~fieldId;
      irqFlag  <= irqSet || (irqFlag && !strb.clrIrq);
    end
  end

  // window decode
  assign pixel     = hCount[H_W-1:2];
  assign hsEnd     = {2'b00, cfg.hsyncW, 2'b00};
  assign burstStop = {1'b0, cfg.burstStart} + {3'b000, cfg.burstW};
  assign pixOn     = cfg.pixSize != 2'd0;
  assign inHWin    = (pixel >= cfg.hStart) && (pixel < cfg.hEnd);
  assign inVWin    = (halfLine >= cfg.vStart) && (halfLine < cfg.vEnd);
  assign inHBurst  = (pixel >= cfg.burstStart) && ({1'b0, pixel} < burstStop);
  assign inVBurst  = (halfLine >= cfg.vbStart) && (halfLine < cfg.vbEnd);

  always_comb begin
    hSync       = pixOn && (hCount < hsEnd);
    vSync       = pixOn && (halfLine < {6'b0, cfg.vsyncW});
    burstEn     = pixOn && inHBurst && inVBurst;
    videoActive = pixOn && inHWin && inVWin;
  end

  assign curLine = curLatch;
  assign lineIrq = irqFlag;

  // R3: between wraps the horizontal counter steps by one
  assert_hstep_R3: assert property (@(posedge clk) disable iff (rst)
    !lineWrap |=> hCount == $past(hCount) + 1'b1);

  // R4: half-line position holds outside advance points
  assert_halfhold_R4: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(halfLine));

  // R8: the field flips only as the half-line counter restarts
  assert_fieldflip_R8: assert property (@(posedge clk) disable iff (rst)
    (fieldId != $past(fieldId)) |-> halfLine == '0);

  // R8: reported line follows the counter at each line start
  assert_linelatch_R8: assert property (@(posedge clk) disable iff (rst)
    lineWrap |=> curLatch == halfLine);

  // R9: a clear strobe without a new match drops the interrupt
  assert_irqclear_R9: assert property (@(posedge clk) disable iff (rst)
    (strb.clrIrq && !irqSet) |=> !lineIrq);

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import vtg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              hSync,
  output logic              vSync,
  output logic              burstEn,
  output logic              videoActive,
  output logic              fieldId,
  output logic              lineIrq
);

  vtgCfg_t        cfg;
  vtgStrobe_t     strb;
  logic [V_W-1:0] curLine;

  vtg_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .curLine(curLine),
    .cfg(cfg), .strb(strb)
  );

  vtg_datapath i_datapath (
    .clk(clk), .rst(rst), .cfg(cfg), .strb(strb), .curLine(curLine),
    .hSync(hSync), .vSync(vSync), .burstEn(burstEn),
    .videoActive(videoActive), .fieldId(fieldId), .lineIrq(lineIrq)
  );

endmodule

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;
  // {address, write data, expected read}
  localparam logic [67:0] REG_VEC [NVEC] = '{
    {4'd0,  32'hFFFF_FFFF, 32'h0001_FFFF},
    {4'd1,  32'hFFFF_FFFF, 32'h0000_0FFF},
    {4'd2,  32'hFFFF_FFFF, 32'h0000_03FF},
    {4'd4,  32'hFFFF_FFFF, 32'h3FFF_FFFF},
    {4'd5,  32'hFFFF_FFFF, 32'h0000_03FF},
    {4'd6,  32'hFFFF_FFFF, 32'h001F_0FFF},
    {4'd7,  32'hFFFF_FFFF, 32'h0FFF_0FFF},
    {4'd8,  32'hFFFF_FFFF, 32'h03FF_03FF},
    {4'd9,  32'hFFFF_FFFF, 32'h03FF_03FF},
    {4'd10, 32'hFFFF_FFFF, 32'h03FF_03FF},
    {4'd11, 32'hFFFF_FFFF, 32'h0000_0000},
    {4'd15, 32'hFFFF_FFFF, 32'h0000_0000},
    {4'd8,  32'h1234_5678, 32'h0234_0278}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [3:0]  busAddr = 4'd3;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic hSync, vSync, burstEn, videoActive, fieldId, lineIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_timing_gen i_raster_timing_gen (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .hSync(hSync), .vSync(vSync),
    .burstEn(burstEn), .videoActive(videoActive), .fieldId(fieldId),
    .lineIrq(lineIrq)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit monOn = 0;
  logic [31:0] sh [16];
  logic [11:0] mh;
  logic [9:0]  mv, mcur;
  logic        mf, mirq;

  function automatic logic [31:0] maskOf(input int a);
    case (a)
      0: return 32'h0001_FFFF;  1: return 32'h0000_0FFF;
      2: return 32'h0000_03FF;  4: return 32'h3FFF_FFFF;
      5: return 32'h0000_03FF;  6: return 32'h001F_0FFF;
      7: return 32'h0FFF_0FFF;  8, 9, 10: return 32'h03FF_03FF;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); #1;
    busAddr = 4'(a); busWdata = d; busWrite = 1'b1;
    @(posedge clk); #1;
    sh[a] = d & maskOf(a);
    @(negedge clk); #1;
    busWrite = 1'b0; busAddr = 4'd3;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); #1;
    busAddr = 4'(a);
    #2 v = busRdata;
  endtask

  // reference model built from the requirements
  always @(posedge clk) begin : model
    int hp, vt, nh, nv;
    bit wh, adv, wv, clr, setI;
    if (rst) begin
      mh <= '0; mv <= '0; mcur <= '0; mf <= 1'b0; mirq <= 1'b0;
    end else begin
      hp  = int'(sh[6][11:0]);
      vt  = int'(sh[5][9:0]);
      wh  = (int'(mh) + 1) >= hp;
      nh  = wh ? 0 : int'(mh) + 1;
      adv = wh || (nh == (hp >> 1));
      wv  = (int'(mv) + 1) >= vt;
      nv  = adv ? (wv ? 0 : int'(mv) + 1) : int'(mv);
      clr = busWrite && busAddr == 4'd3;
      setI = adv && (nv == int'(sh[2][9:0]));
      mh <= 12'(nh);
      mv <= 10'(nv);
      if (wh) mcur <= 10'(nv);
      if (adv && wv) mf <= ~mf;
      mirq <= setI || (mirq && !clr);
    end
  end

  always @(negedge clk) begin : monitor
    int px;
    bit on;
    if (monOn) begin
      on = sh[0][1:0] != 2'd0;
      px = int'(mh) >> 2;
      check("R3 hSync", 32'(hSync), 32'(on && int'(mh) < int'(sh[4][7:0]) * 4));
      check("R5 vSync", 32'(vSync), 32'(on && int'(mv) < int'(sh[4][19:16])));
      check("R6 videoActive", 32'(videoActive), 32'(on &&
            px >= int'(sh[8][25:16]) && px < int'(sh[8][9:0]) &&
            int'(mv) >= int'(sh[9][25:16]) && int'(mv) < int'(sh[9][9:0])));
      check("R7 burstEn", 32'(burstEn), 32'(on &&
            px >= int'(sh[4][29:20]) && px < int'(sh[4][29:20]) + int'(sh[4][15:8]) &&
            int'(mv) >= int'(sh[10][25:16]) && int'(mv) < int'(sh[10][9:0])));
      check("R8 fieldId", 32'(fieldId), 32'(mf));
      check("R9 lineIrq", 32'(lineIrq), 32'(mirq));
      if (busAddr == 4'd3 && !busWrite)
        check("R4 R8 curLine", busRdata, 32'(mcur));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic risePeriod(input string req, input bit useH, input int expP);
    int t0;
    bit prev, cur;
    t0 = -1; prev = 1'b1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      cur = useH ? hSync : vSync;
      if (cur && !prev) begin
        if (t0 < 0) t0 = cyc;
        else begin check(req, 32'(cyc - t0), 32'(expP)); return; end
      end
      prev = cur;
    end
    check(req, 32'hFFFF_FFFF, 32'(expP));
  endtask

  initial begin
    logic [31:0] v, c0, c1;
    for (int i = 0; i < 16; i++) sh[i] = '0;
    sh[2] = 32'h3FF;

    // R2: reset state
    repeat (2) @(negedge clk);
    for (int a = 0; a < 11; a++) begin
      rd(a, v);
      check("R2 reset register", v, (a == 2) ? 32'h3FF : 32'h0);
    end
    check("R2 reset outputs", 32'({hSync, vSync, burstEn, videoActive, fieldId, lineIrq}), 32'h0);
    @(negedge clk); #1 rst = 1'b0; busAddr = 4'd3;
    monOn = 1;

    // R1: register masks and read-back
    for (int i = 0; i < NVEC; i++) begin
      wr(int'(REG_VEC[i][67:64]), REG_VEC[i][63:32]);
      rd(int'(REG_VEC[i][67:64]), v);
      check("R1 read-back", v, REG_VEC[i][31:0]);
    end

    // scenario A: 40 quarter-pixel line, 7 half-line field
    wr(0, 32'h0);
    wr(6, 32'd40);
    wr(5, 32'd7);
    wr(4, 32'h0032_0202);
    wr(8, 32'h0004_0009);
    wr(9, 32'h0002_0006);
    wr(10, 32'h0001_0005);
    wr(2, 32'd3);
    wr(7, 32'h0C15_0C15);
    wr(1, 32'h140);
    wr(0, 32'h0000_0002);
    risePeriod("R3 hsync period", 1'b1, 40);
    risePeriod("R4 vsync period", 1'b0, 140);
    for (int k = 0; k < 400 && !lineIrq; k++) @(negedge clk);
    check("R9 interrupt raised", 32'(lineIrq), 32'h1);
    wr(3, 32'h0);
    check("R9 interrupt cleared", 32'(lineIrq), 32'h0);
    repeat (400) @(negedge clk);

    // scenario B: odd line, even field, new interrupt line, reprogrammed live
    wr(0, 32'h0000_0003);
    wr(6, 32'd33);
    wr(5, 32'd8);
    wr(2, 32'd5);
    wr(4, 32'h0011_0301);
    repeat (300) @(negedge clk);
    risePeriod("R3 odd hsync period", 1'b1, 33);
    wr(3, 32'h0);
    repeat (300) @(negedge clk);

    // R10: blank pixel size
    wr(0, 32'h0001_F000);
    rd(3, c0);
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      check("R10 blank outputs", 32'({hSync, vSync, burstEn, videoActive}), 32'h0);
    end
    rd(3, c1);
    check("R10 counters run", 32'(c1 != c0), 32'h1);
    @(negedge clk); #1 busAddr = 4'd3;
    repeat (20) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule